// File: doc/BRIEF.md
# SPI Serial Save-Memory Device

This block models a byte-addressed save memory, of the EEPROM or flash kind, that sits behind a four-wire SPI slave port. It is used in mode 0. The host lowers chip select and clocks bytes most significant bit first. MOSI is sampled on each rising SCK edge, and MISO changes after each falling edge. The first byte of every selection is an opcode. The status and write-enable opcodes take effect as soon as that byte ends. The read and write opcodes first collect an address, most significant byte first. That address is two bytes for the EEPROM variant and three bytes for the flash variant. After the address, data bytes stream to or from a small internal array, and the address steps up by one after each byte.

The array holds the erased value 0xFF after reset. A write lands only while the write-enable latch is set. Raising chip select after a write command drops that latch. The SPI pins are brought into the system clock domain through a short synchronizer. SCK must therefore be slow compared with the system clock.

Top module: `saveMemSpi`

## Requirements
- R1: The first complete byte after chip select falls is decoded as the opcode, and the address accumulator clears at that point. Raising chip select in the middle of a byte discards the partial byte, and the next selection starts again at the opcode.
- R2: A read or write opcode is followed by ADDR_BYTES address bytes, most significant byte first. ADDR_BYTES is 2 by default (FLASH_TYPE=0) and 3 when FLASH_TYPE=1. The array location is the address modulo DEPTH.
- R3: Opcode 0x06 sets status bit 1 (write enable). Opcode 0x04 clears it.
- R4: After opcode 0x05, every following byte on MISO is the status register. Bit 1 is write enable and all other bits are 0.
- R5: In a 0x03 read, each data byte returns the array byte at the current address, and the address then increments.
- R6: In a 0x02 write, each data byte is stored at the current address while write enable is set, and the address then increments.
- R7: MISO carries 0xFF during the opcode byte, during address bytes, and on every byte that follows an unsupported opcode.
- R8: After reset, every array location reads 0xFF, MISO is high and write enable is clear.
- R9: A 0x02 write with write enable clear leaves the array unchanged. Chip select rising after a 0x02 command clears write enable.
- R10: Address increments wrap from DEPTH-1 to 0, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from host, MSB first |
| miso | output | 1 | Serial data to host, MSB first |

## Verification
Status reads are tried before and after each write-enable change. They separate the set and clear opcodes, and they show whether deselecting after a write drops the latch. Multi-byte writes followed by longer reads show that the address increments and that untouched neighbours still hold 0xFF. A write at the top of the array shows the wrap to location 0. A write at address 0x0034 read back at 0x3400 distinguishes most-significant-first address order from the reverse. A write with write enable clear, an unsupported opcode and a selection aborted mid-byte each show that the array and the command state are left alone.

// File: rtl/saveMemPkg.sv
package saveMemPkg;

  typedef enum logic [1:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_DATA
  } phase_t;

  typedef enum logic [1:0] {
    TX_ONES,
    TX_STATUS,
    TX_MEM
  } txSel_t;

  // strobes from the command control to the storage datapath
  typedef struct packed {
    logic clrAddr;
    logic addrShift;
    logic incAddr;
    logic memWrite;
    logic setWel;
    logic clrWel;
  } dpStrobe_t;

  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRDIS  = 8'h04;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_WREN   = 8'h06;

endpackage

// File: rtl/saveMemCtrl.sv
module saveMemCtrl
  import saveMemPkg::*;
#(
  parameter int ADDR_BYTES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] statusByte,
  input  logic [7:0] rdByte,
  output dpStrobe_t  strobe,
  output logic [7:0] rxByte,
  output logic       miso
);

  localparam int ALW = (ADDR_BYTES > 2) ? $clog2(ADDR_BYTES) : 1;

  logic [SYNC_STAGES-1:0] csPipe, sckPipe, mosiPipe;
  logic csS, sckS, mosiS, csPrev, sckPrev;
  logic csActive, csRise, sckRise, sckFall, byteDone;

  logic [2:0]     bitCnt;
  logic [6:0]     rxShift;
  logic [7:0]     txShift, txByte;
  logic [7:0]     opcode, opcodeNext;
  phase_t         phase, phaseNext;
  logic [ALW-1:0] addrLeft, addrLeftNext;
  txSel_t         txSel;

  // input synchronizers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sckPipe  <= '0;
      mosiPipe <= '0;
      csPrev   <= 1'b1;
      sckPrev  <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sckPipe  <= {sckPipe[SYNC_STAGES-2:0], sck};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      csPrev   <= csS;
      sckPrev  <= sckS;
    end
  end

  assign csS      = csPipe[SYNC_STAGES-1];
  assign sckS     = sckPipe[SYNC_STAGES-1];
  assign mosiS    = mosiPipe[SYNC_STAGES-1];
  assign csActive = !csS;
  assign csRise   = csS && !csPrev;
  assign sckRise  = csActive && sckS && !sckPrev;
  assign sckFall  = csActive && !sckS && sckPrev;
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign rxByte   = {rxShift, mosiS};

  // command decode
  always_comb begin
    strobe       = '0;
    txSel        = TX_ONES;
    phaseNext    = phase;
    addrLeftNext = addrLeft;
    opcodeNext   = opcode;
    if (csRise && opcode == OP_WRITE) strobe.clrWel = 1'b1;
    if (byteDone) begin
      unique case (phase)
        PH_OPCODE: begin
          opcodeNext     = rxByte;
          strobe.clrAddr = 1'b1;
          phaseNext      = PH_DATA;
          case (rxByte)
            OP_WREN:   strobe.setWel = 1'b1;
            OP_WRDIS:  strobe.clrWel = 1'b1;
            OP_RDSTAT: txSel = TX_STATUS;
            OP_READ, OP_WRITE: begin
              phaseNext    = PH_ADDR;
              addrLeftNext = ALW'(ADDR_BYTES - 1);
            end
            default: ;
          endcase
        end
        PH_ADDR: begin
          strobe.addrShift = 1'b1;
          if (addrLeft == '0) begin
            phaseNext = PH_DATA;
            if (opcode == OP_READ) txSel = TX_MEM;
          end else begin
            addrLeftNext = addrLeft - 1'b1;
          end
        end
        default: begin
          case (opcode)
            OP_READ: begin
              strobe.incAddr = 1'b1;
              txSel          = TX_MEM;
            end
            OP_WRITE: begin
              strobe.memWrite = 1'b1;
              strobe.incAddr  = 1'b1;
            end
            OP_RDSTAT: txSel = TX_STATUS;
            default: ;
          endcase
        end
      endcase
    end
  end

  always_comb begin
    unique case (txSel)
      TX_STATUS: txByte = statusByte;
      TX_MEM:    txByte = rdByte;
      default:   txByte = 8'hFF;
    endcase
  end

  // byte framing and shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= 8'hFF;
      opcode   <= '0;
      phase    <= PH_OPCODE;
      addrLeft <= '0;
    end else if (!csActive) begin
      bitCnt   <= '0;
      txShift  <= 8'hFF;
      opcode   <= '0;
      phase    <= PH_OPCODE;
      addrLeft <= '0;
    end else begin
      if (sckRise) begin
        rxShift <= rxByte[6:0];
        bitCnt  <= bitCnt + 3'd1;
      end
      if (byteDone) begin
        phase    <= phaseNext;
        opcode   <= opcodeNext;
        addrLeft <= addrLeftNext;
        txShift  <= txByte;
      end else if (sckFall && bitCnt != 3'd0) begin
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  assign miso = txShift[7];

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (bitCnt == 3'd0 && txShift == 8'hFF && phase == PH_OPCODE)); // R1

  AST_WRITE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWrite |-> (opcode == OP_WRITE && phase == PH_DATA)); // R6

  AST_ADDR_PHASE_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && phase == PH_ADDR) |-> (txShift == 8'hFF)); // R7

endmodule

// File: rtl/saveMemDatapath.sv
module saveMemDatapath
  import saveMemPkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [7:0] rxByte,
  output logic [7:0] statusByte,
  output logic [7:0] rdByte
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] addrAcc, rdIdx;
  logic             wel;
  logic [7:0]       mem [DEPTH];

  // only the low IDX_W bits of the shifted address survive: modulo DEPTH
  always_comb begin
    if (strobe.addrShift)     rdIdx = IDX_W'({addrAcc, rxByte});
    else if (strobe.incAddr)  rdIdx = addrAcc + IDX_W'(1);
    else                      rdIdx = addrAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrAcc <= '0;
      wel     <= 1'b0;
    end else begin
      if (strobe.clrAddr) addrAcc <= '0;
      else                addrAcc <= rdIdx;
      if (strobe.setWel)      wel <= 1'b1;
      else if (strobe.clrWel) wel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (strobe.memWrite && wel) begin
      mem[addrAcc] <= rxByte;
    end
  end

  assign statusByte = {6'b0, wel, 1'b0};
  assign rdByte     = mem[rdIdx];

  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setWel |=> wel); // R3

  AST_WEL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrWel && !strobe.setWel) |=> !wel); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incAddr && !strobe.clrAddr) |=> addrAcc == $past(addrAcc) + IDX_W'(1)); // R10

  AST_WRITE_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.memWrite && !wel) |=> mem[$past(addrAcc)] == $past(mem[addrAcc])); // R9

endmodule

// File: rtl/saveMemSpi.sv
module saveMemSpi
  import saveMemPkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int FLASH_TYPE  = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  output logic miso
);

  localparam int ADDR_BYTES = (FLASH_TYPE != 0) ? 3 : 2;

  dpStrobe_t  strobe;
  logic [7:0] rxByte, statusByte, rdByte;

  saveMemCtrl #(
    .ADDR_BYTES (ADDR_BYTES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sck       (sck),
    .mosi      (mosi),
    .statusByte(statusByte),
    .rdByte    (rdByte),
    .strobe    (strobe),
    .rxByte    (rxByte),
    .miso      (miso)
  );

  saveMemDatapath #(
    .DEPTH(DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rxByte    (rxByte),
    .statusByte(statusByte),
    .rdByte    (rdByte)
  );

endmodule

// File: tb/saveMemSpi_bench.sv
module saveMemSpi_bench;

  localparam int HALF  = 8;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  always #5 clk = ~clk;

  saveMemSpi u_saveMemSpi (
    .clk (clk),
    .rstN(rstN),
    .csN (csN),
    .sck (sck),
    .mosi(mosi),
    .miso(miso)
  );

  typedef struct {
    logic [7:0] exp;
    int         req;
  } expItem_t;

  expItem_t   sbQ[$];
  int         vectors = 0;
  int         misses  = 0;
  bit         done    = 0;
  logic [7:0] model [DEPTH];
  bit         mWel    = 0;

  // monitor: assembles MISO bytes and compares against the scoreboard
  logic [7:0] mBits = '0;
  int         mCnt  = 0;
  always @(posedge sck or posedge csN) begin
    if (csN) begin
      mCnt = 0;
    end else begin
      mBits = {mBits[6:0], miso};
      mCnt++;
      if (mCnt == 8) begin
        mCnt = 0;
        vectors++;
        if (sbQ.size() == 0) begin
          misses++;
          $display("FAIL R%0d: unexpected byte %02h, scoreboard empty", 1, mBits);
        end else begin
          expItem_t it;
          it = sbQ.pop_front();
          if (mBits !== it.exp) begin
            misses++;
            $display("FAIL R%0d: miso byte %02h, expected %02h", it.req, mBits, it.exp);
          end
        end
      end
    end
  end

  task automatic spiByte(input logic [7:0] d, input int nbits = 8);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sendExp(input logic [7:0] d, input logic [7:0] e, input int req);
    expItem_t it;
    it.exp = e;
    it.req = req;
    sbQ.push_back(it);
    spiByte(d);
  endtask

  task automatic beginTx();
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic endTx();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic cmdSimple(input logic [7:0] op, input int req);
    beginTx();
    sendExp(op, 8'hFF, req);
    endTx();
    if (op == 8'h06) mWel = 1;
    if (op == 8'h04) mWel = 0;
  endtask

  task automatic rdStatus(input int n, input int req);
    beginTx();
    sendExp(8'h05, 8'hFF, 7);
    for (int i = 0; i < n; i++) sendExp(8'h00, {6'b0, mWel, 1'b0}, req);
    endTx();
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input int n);
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    beginTx();
    sendExp(8'h02, 8'hFF, 7);
    sendExp(a[15:8], 8'hFF, 7);
    sendExp(a[7:0], 8'hFF, 7);
    for (int i = 0; i < n; i++) begin
      sendExp(d[i], 8'hFF, 7);
      if (mWel) model[(int'(a) + i) % DEPTH] = d[i];
    end
    endTx();
    mWel = 0;
  endtask

  task automatic doRead(input logic [15:0] a, input int n, input int req);
    beginTx();
    sendExp(8'h03, 8'hFF, 7);
    sendExp(a[15:8], 8'hFF, 7);
    sendExp(a[7:0], 8'hFF, 7);
    for (int i = 0; i < n; i++) sendExp(8'h00, model[(int'(a) + i) % DEPTH], req);
    endTx();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R8: reset state, MISO idles high
    vectors++;
    if (miso !== 1'b1) begin
      misses++;
      $display("FAIL R8: miso %b after reset, expected 1", miso);
    end
    rdStatus(1, 8);              // R8: write enable clear
    doRead(16'h0080, 2, 8);      // R8: erased array

    // R3 / R4: write-enable latch via status
    cmdSimple(8'h06, 3);
    rdStatus(2, 4);              // R4: repeated status bytes, R3 set
    cmdSimple(8'h04, 3);
    rdStatus(1, 3);              // R3: cleared

    // R9: write with latch clear is dropped
    doWrite(16'h0010, 8'hAA, 8'h00, 8'h00, 1);
    doRead(16'h0010, 1, 9);

    // R6 / R5: multi-byte write then streaming read
    cmdSimple(8'h06, 6);
    doWrite(16'h0010, 8'h11, 8'h22, 8'h33, 3);
    rdStatus(1, 9);              // R9: latch dropped at deselect
    doRead(16'h000F, 5, 5);      // R5: neighbours still erased

    // R10: wrap of write and read
    cmdSimple(8'h06, 10);
    doWrite(16'h00FF, 8'hC3, 8'h3C, 8'h00, 2);
    doRead(16'h00FE, 4, 10);

    // R2: MSB-first address, modulo DEPTH
    cmdSimple(8'h06, 2);
    doWrite(16'h0034, 8'h5A, 8'h00, 8'h00, 1);
    doRead(16'h3400, 1, 2);      // lands at location 0x00
    doRead(16'h1234, 1, 2);      // lands at location 0x34

    // R7: unsupported opcode returns ones
    beginTx();
    sendExp(8'h9F, 8'hFF, 7);
    for (int i = 0; i < 3; i++) sendExp(8'h00, 8'hFF, 7);
    endTx();

    // R1: deselect mid-byte, then a clean command
    beginTx();
    spiByte(8'h06, 4);
    endTx();
    rdStatus(1, 1);              // R1: partial 0x06 had no effect
    cmdSimple(8'h06, 1);
    rdStatus(1, 1);

    repeat (4 * HALF) @(negedge clk);
    if (sbQ.size() != 0) begin
      misses++;
      $display("FAIL R1: %0d expected bytes never seen, expected 0", sbQ.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL R1: watchdog expired, got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule